// File: doc/BRIEF.md
# Descriptor-Driven Disk Channel DMA Engine

This block is the bus-master DMA engine for one channel of a parallel disk interface. The host programs it through a small byte-addressed register window that holds a command byte, a status byte and a 32-bit pointer to a table of descriptors in memory. The host issues the drive command first, then sets the start bit. From that point the engine walks the descriptor table on its own. It reads each 8-byte descriptor through a single-word read port, then emits one beat address for every 4 bytes of that descriptor on a valid/ready beat interface. A separate data mover between memory and the drive acts on those beats.

The walk ends after the descriptor whose end marker is set. The engine then drops its active flag and raises the interrupt flag, both on the same clock edge. A memory fault during a fetch ends the walk with the error flag set. So does a table that runs out while the drive still reports pending data. The host can abort a walk by clearing the start bit. The engine then stops at the next beat or fetch boundary and raises nothing.

Top module: `bmdma_channel`

## Requirements
- R1: Register window, byte offsets on `reg_addr`. Offset 0 is the command byte: bit 0 is start and bit 3 is direction, and all other bits read 0. Offset 2 is the status byte. Offset 4 is the 32-bit table pointer, accessed as a whole word. Reads at offsets 1, 3, 5, 6 and 7 return 0, and writes there change nothing.
- R2: Bits 1:0 of the table pointer always read 0.
- R3: Status bit 0 is the read-only active flag. Status bits 5 and 6 are plain read/write flags for drive 0 and drive 1. Status bits 3, 4 and 7 read 0.
- R4: Status bit 1 (error) and bit 2 (interrupt) are cleared by writing 1 to them. Writing 0 leaves them unchanged. If a completion event and a clearing write fall in the same cycle, the event wins.
- R5: Writing 1 to command bit 0 starts a walk only when that bit was 0 and the engine is idle. The active flag reads 1 from the next cycle on. The first read request goes to the pointer address, and the second to pointer+4.
- R6: Each descriptor has two words. Word 0 is the start address. In word 1, bits 15:0 are the byte count, where 0 means 65536, and bit 31 marks the final descriptor. A descriptor gives ceil(count/4) beats at addresses that rise by 4 from word 0. The next descriptor sits 8 bytes further on.
- R7: `xfer_to_mem` follows command bit 3, where 1 means device to memory. Writes to bit 3 are ignored while the engine is active.
- R8: When the final beat of the final descriptor is accepted with `dev_pending` low, status bits 2:0 read 100 from the next cycle on and `irq` is high.
- R9: A fetch acknowledged with `mem_rd_err` high ends the walk. So does acceptance of the final beat while `dev_pending` is high. In both cases status bits 2:0 read 110 from the next cycle on.
- R10: Clearing the start bit while active ends the walk at the next accepted beat or fetch acknowledge. The active flag clears, the error and interrupt flags stay unchanged, and no further beats or requests follow.
- R11: Once a beat is offered, `xfer_valid` stays high and `xfer_addr` stays stable until `xfer_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Byte offset in the register window |
| reg_wdata | input | 32 | Write data; byte registers use bits 7:0 |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt flag (status bit 2) |
| mem_rd_req | output | 1 | Descriptor word read request |
| mem_rd_addr | output | 32 | Descriptor word address |
| mem_rd_ack | input | 1 | Read completes this cycle |
| mem_rd_data | input | 32 | Read data, valid with `mem_rd_ack` |
| mem_rd_err | input | 1 | Read fault, valid with `mem_rd_ack` |
| xfer_valid | output | 1 | A beat is offered |
| xfer_addr | output | 32 | Memory address of the offered beat |
| xfer_ready | input | 1 | Data mover accepts the beat |
| xfer_to_mem | output | 1 | Beat direction, 1 = device to memory |
| dev_pending | input | 1 | Drive still holds data to move |

## Verification
Register reads are combinational, so a write becomes visible on the read port in the cycle after the edge that captures it. The active flag and the first fetch request appear right after the start write's edge. The completion or error pattern lands on the very edge that accepts the final beat or the faulting acknowledge. The bench drives every input on the falling edge and reads every output there too, half a cycle clear of the edge that changes it. It compares each accepted beat address against an address walk it derives from its own copy of the descriptor table. After each walk ends, it checks the three low status bits as the requirements predict for that outcome.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  typedef enum logic [1:0] {
    W_IDLE    = 2'd0,
    W_FETCH_A = 2'd1,
    W_FETCH_L = 2'd2,
    W_XFER    = 2'd3
  } walk_state_t;

  // Number of beats of 2**lg bytes needed for a 16-bit count (0 = 65536 bytes).
  function automatic logic [16:0] beats_for_len(input logic [15:0] len, input int unsigned lg);
    logic [17:0] bytes;
    bytes = (len == 16'd0) ? 18'h10000 : {2'b00, len};
    bytes = bytes + ((18'd1 << lg) - 18'd1);
    return 17'(bytes >> lg);
  endfunction

  // Descriptors are two words long.
  function automatic logic [31:0] next_desc(input logic [31:0] p);
    return p + 32'd8;
  endfunction

endpackage

// File: rtl/bmdma_regs.sv
module bmdma_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        busy,
  input  logic        end_ok,
  input  logic        end_err,
  output logic        start_pulse,
  output logic        run_en,
  output logic        dir_to_mem,
  output logic [31:0] table_ptr,
  output logic        irq_flag
);
  logic        cmd_start, cmd_dir, err_f, irq_f;
  logic [1:0]  drv_f;
  logic [29:0] ptr_q;
  logic        wr_cmd, wr_sts, wr_ptr;

  assign wr_cmd = wr && (addr == 3'd0);
  assign wr_sts = wr && (addr == 3'd2);
  assign wr_ptr = wr && (addr == 3'd4);

  assign start_pulse = wr_cmd && wdata[0] && !cmd_start && !busy;
  assign run_en      = cmd_start;
  assign dir_to_mem  = cmd_dir;
  assign table_ptr   = {ptr_q, 2'b00};
  assign irq_flag    = irq_f;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_start <= 1'b0;
      cmd_dir   <= 1'b0;
      err_f     <= 1'b0;
      irq_f     <= 1'b0;
      drv_f     <= 2'b00;
      ptr_q     <= '0;
    end else begin
      if (wr_cmd) begin
        cmd_start <= wdata[0];
        if (!busy) cmd_dir <= wdata[3];
      end
      if (end_err)                 err_f <= 1'b1;
      else if (wr_sts && wdata[1]) err_f <= 1'b0;
      if (end_ok || end_err)       irq_f <= 1'b1;
      else if (wr_sts && wdata[2]) irq_f <= 1'b0;
      if (wr_sts) drv_f <= wdata[6:5];
      if (wr_ptr) ptr_q <= wdata[31:2];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      3'd0:    rdata = {24'd0, 4'd0, cmd_dir, 2'b00, cmd_start};
      3'd2:    rdata = {24'd0, 1'b0, drv_f, 2'b00, irq_f, err_f, busy};
      3'd4:    rdata = {ptr_q, 2'b00};
      default: rdata = '0;
    endcase
  end

  p_done_pattern_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ok && !end_err) |=> (irq_f && !err_f && !busy));
  p_err_pattern_r9: assert property (@(posedge clk) disable iff (!rst_n)
    end_err |=> (irq_f && err_f && !busy));
  p_w0_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !wdata[2] && !end_ok && !end_err) |=> $stable(irq_f));
  p_abort_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && !$past(end_ok || end_err) && !$past(wr_sts)) |-> ($stable(irq_f) && $stable(err_f)));
  p_dir_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_dir));
endmodule

// File: rtl/bmdma_walker.sv
module bmdma_walker
  import bmdma_pkg::*;
#(
  parameter int unsigned BEAT_LG = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        run_en,
  input  logic [31:0] table_ptr,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [31:0] mem_rd_data,
  input  logic        mem_rd_err,
  output logic        xfer_valid,
  output logic [31:0] xfer_addr,
  input  logic        xfer_ready,
  input  logic        dev_pending,
  output logic        busy,
  output logic        end_ok,
  output logic        end_err
);
  localparam logic [31:0] BEAT_STEP = 32'd1 << BEAT_LG;

  walk_state_t st;
  logic [31:0] dptr, baddr;
  logic [16:0] left;
  logic        last_f;
  logic        ack_ev, beat_hs, final_beat;

  assign busy        = (st != W_IDLE);
  assign mem_rd_req  = (st == W_FETCH_A) || (st == W_FETCH_L);
  assign mem_rd_addr = (st == W_FETCH_L) ? (dptr + 32'd4) : dptr;
  assign xfer_valid  = (st == W_XFER);
  assign xfer_addr   = baddr;

  assign ack_ev     = mem_rd_req && mem_rd_ack;
  assign beat_hs    = xfer_valid && xfer_ready;
  assign final_beat = beat_hs && (left == 17'd1) && last_f;
  assign end_err    = run_en && ((ack_ev && mem_rd_err) || (final_beat && dev_pending));
  assign end_ok     = run_en && final_beat && !dev_pending;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= W_IDLE;
      dptr   <= '0;
      baddr  <= '0;
      left   <= '0;
      last_f <= 1'b0;
    end else begin
      case (st)
        W_IDLE: if (start) begin
          st   <= W_FETCH_A;
          dptr <= table_ptr;
        end
        W_FETCH_A: if (mem_rd_ack) begin
          if (!run_en || mem_rd_err) st <= W_IDLE;
          else begin
            baddr <= mem_rd_data;
            st    <= W_FETCH_L;
          end
        end
        W_FETCH_L: if (mem_rd_ack) begin
          if (!run_en || mem_rd_err) st <= W_IDLE;
          else begin
            left   <= beats_for_len(mem_rd_data[15:0], BEAT_LG);
            last_f <= mem_rd_data[31];
            st     <= W_XFER;
          end
        end
        W_XFER: if (xfer_ready) begin
          if (!run_en) st <= W_IDLE;
          else begin
            baddr <= baddr + BEAT_STEP;
            left  <= left - 17'd1;
            if (left == 17'd1) begin
              if (last_f) st <= W_IDLE;
              else begin
                dptr <= next_desc(dptr);
                st   <= W_FETCH_A;
              end
            end
          end
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  p_hold_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_addr)));
  p_fetch_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |-> (left != 17'd0));
  p_stop_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_en && (ack_ev || beat_hs)) |=> !busy);
endmodule

// File: rtl/bmdma_channel.sv
module bmdma_channel #(
  parameter int unsigned BEAT_LG = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic [31:0] mem_rd_data,
  input  logic        mem_rd_err,
  output logic        xfer_valid,
  output logic [31:0] xfer_addr,
  input  logic        xfer_ready,
  output logic        xfer_to_mem,
  input  logic        dev_pending
);
  logic        busy, end_ok, end_err, start_pulse, run_en;
  logic [31:0] table_ptr;

  bmdma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .end_ok(end_ok), .end_err(end_err),
    .start_pulse(start_pulse), .run_en(run_en), .dir_to_mem(xfer_to_mem),
    .table_ptr(table_ptr), .irq_flag(irq)
  );

  bmdma_walker #(.BEAT_LG(BEAT_LG)) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start_pulse), .run_en(run_en),
    .table_ptr(table_ptr), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_ready(xfer_ready),
    .dev_pending(dev_pending), .busy(busy), .end_ok(end_ok), .end_err(end_err)
  );
endmodule

// File: tb/sim_bmdma_channel.sv
module sim_bmdma_channel;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq, mem_rd_req, mem_rd_ack = 1'b0, mem_rd_err = 1'b0;
  logic [31:0] mem_rd_addr, mem_rd_data = '0, xfer_addr;
  logic xfer_valid, xfer_ready = 1'b0, xfer_to_mem, dev_pending = 1'b0;

  bmdma_channel u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ack(mem_rd_ack), .mem_rd_data(mem_rd_data), .mem_rd_err(mem_rd_err),
    .xfer_valid(xfer_valid), .xfer_addr(xfer_addr), .xfer_ready(xfer_ready),
    .xfer_to_mem(xfer_to_mem), .dev_pending(dev_pending)
  );

  always #5 clk = ~clk;

  localparam logic [31:0] TBL = 32'h0000_0100;
  logic [31:0] bmem [0:63];
  int checks = 0, errors = 0;
  bit done_flag = 0, mem_fail = 0, ready_on = 1;
  logic [31:0] mon_ptr, mon_addr;
  int mon_left, mon_beats, mon_bad;

  function automatic int tb_beats(input logic [15:0] len);
    int b;
    b = (len == 16'd0) ? 65536 : int'(len);
    return (b + 3) / 4;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic put_desc(input int idx, input logic [31:0] a, input logic [15:0] len, input bit last);
    bmem[2*idx]   = a;
    bmem[2*idx+1] = {last, 15'd0, len};
  endtask

  task automatic start_job(input bit dir);
    mon_ptr = TBL; mon_left = 0; mon_beats = 0; mon_bad = 0;
    wr(3'd4, TBL);
    wr(3'd0, {28'd0, dir, 3'd0});
    wr(3'd0, {28'd0, dir, 3'd1});
  endtask

  task automatic wait_idle(output logic [31:0] s);
    do rd(3'd2, s); while (s[0]);
  endtask

  task automatic clear_all();
    wr(3'd2, 32'h06);
    wr(3'd0, 32'h0);
  endtask

  // memory and data-mover responders plus beat monitor
  initial forever begin
    @(negedge clk);
    mem_rd_ack  = mem_rd_req && ($urandom_range(0, 2) != 0);
    mem_rd_data = bmem[mem_rd_addr[7:2]];
    mem_rd_err  = mem_rd_ack && mem_fail;
    xfer_ready  = ready_on && ($urandom_range(0, 3) != 0);
    if (xfer_valid && xfer_ready) begin
      if (mon_left == 0) begin
        mon_addr = bmem[mon_ptr[7:2]];
        mon_left = tb_beats(bmem[mon_ptr[7:2] + 6'd1][15:0]);
        mon_ptr  = mon_ptr + 32'd8;
      end
      if (xfer_addr != mon_addr) begin
        mon_bad++;
        if (mon_bad == 1) $display("FAIL R6 beat addr actual=%h expected=%h", xfer_addr, mon_addr);
      end
      mon_addr = mon_addr + 32'd4;
      mon_left--;
      mon_beats++;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int exp_b, n, b0;
    bit dir;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 64; i++) bmem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(3'd2, d); chk(d == 0 && !irq, "R3 reset status", d, 0);
    rd(3'd0, d); chk(d == 0, "R1 reset cmd", d, 0);
    rd(3'd4, d); chk(d == 0, "R1 reset ptr", d, 0);
    chk(!mem_rd_req && !xfer_valid, "R5 idle outputs", {mem_rd_req, xfer_valid}, 0);

    // register window
    wr(3'd4, 32'h1234_5677); rd(3'd4, d); chk(d == 32'h1234_5674, "R2 ptr low bits", d, 32'h1234_5674);
    wr(3'd2, 32'hF9); rd(3'd2, d); chk(d == 32'h60, "R3 status rw/ro bits", d, 32'h60);
    wr(3'd1, 32'hFF); wr(3'd3, 32'hFF);
    rd(3'd1, d); chk(d == 0, "R1 offset 1 reads zero", d, 0);
    rd(3'd2, d); chk(d == 32'h60, "R1 reserved write ignored", d, 32'h60);
    rd(3'd5, d); chk(d == 0, "R1 offset 5 reads zero", d, 0);
    wr(3'd0, 32'h08); rd(3'd0, d); chk(d == 32'h08 && xfer_to_mem, "R7 dir bit", d, 32'h08);
    wr(3'd0, 32'hF6); rd(3'd0, d); chk(d == 0, "R1 cmd unused bits", d, 0);
    wr(3'd2, 32'h00); rd(3'd2, d); chk(d == 0, "R3 drive flags clear", d, 0);

    // directed job: three descriptors, one with an odd count
    put_desc(0, 32'h0001_0000, 16'd8, 0);
    put_desc(1, 32'h0002_0100, 16'd6, 0);
    put_desc(2, 32'h0003_0FF0, 16'd12, 1);
    start_job(1'b0);
    rd(3'd2, d); chk(d[0] == 1'b1, "R5 active after start", d, 1);
    wait_idle(d);
    chk(d[2:0] == 3'b100 && irq, "R8 completion pattern", d, 32'h4);
    chk(mon_beats == 7 && mon_bad == 0, "R6 beat walk", mon_beats, 7);
    chk(!xfer_to_mem, "R7 memory-to-device", xfer_to_mem, 0);
    // W1C semantics
    wr(3'd2, 32'h02); rd(3'd2, d); chk(d[2:0] == 3'b100, "R4 write 1 to err keeps irq", d, 32'h4);
    wr(3'd2, 32'h00); rd(3'd2, d); chk(d[2:0] == 3'b100, "R4 write 0 keeps irq", d, 32'h4);
    wr(3'd2, 32'h04); rd(3'd2, d); chk(d[2:0] == 3'b000 && !irq, "R4 write 1 clears irq", d, 0);
    wr(3'd0, 32'h0);

    // table ends while the device still has data
    dev_pending = 1'b1;
    start_job(1'b1);
    wait_idle(d);
    chk(d[2:0] == 3'b110, "R9 pending at table end", d, 32'h6);
    chk(mon_beats == 7, "R9 all beats moved", mon_beats, 7);
    dev_pending = 1'b0;
    clear_all();

    // memory fault on fetch
    mem_fail = 1'b1;
    start_job(1'b0);
    wait_idle(d);
    chk(d[2:0] == 3'b110, "R9 fetch fault", d, 32'h6);
    chk(mon_beats == 0, "R9 no beats after fault", mon_beats, 0);
    mem_fail = 1'b0;
    clear_all();

    // full 64 KB descriptor
    put_desc(0, 32'h0010_0000, 16'd0, 1);
    start_job(1'b1);
    wait_idle(d);
    chk(d[2:0] == 3'b100, "R8 64KB completion", d, 32'h4);
    chk(mon_beats == 16384 && mon_bad == 0, "R6 zero count is 65536 bytes", mon_beats, 16384);
    clear_all();

    // abort mid-walk; direction change ignored while active
    start_job(1'b1);
    repeat (40) @(negedge clk);
    wr(3'd0, 32'h01);
    rd(3'd0, d); chk(d == 32'h09 && xfer_to_mem, "R7 dir write ignored while active", d, 32'h09);
    wr(3'd0, 32'h00);
    repeat (10) @(negedge clk);
    rd(3'd2, d); chk(d[2:0] == 3'b000 && !irq, "R10 abort raises nothing", d, 0);
    b0 = mon_beats;
    repeat (20) @(negedge clk);
    chk(mon_beats == b0 && b0 > 0 && b0 < 16384 && !xfer_valid && !mem_rd_req, "R10 no beats after abort", mon_beats, b0);

    // held beat while not ready
    ready_on = 1'b0;
    put_desc(0, 32'h0040_0000, 16'd4, 1);
    start_job(1'b0);
    repeat (12) @(negedge clk);
    chk(xfer_valid && xfer_addr == 32'h0040_0000, "R11 beat held", xfer_addr, 32'h0040_0000);
    ready_on = 1'b1;
    wait_idle(d);
    chk(d[2:0] == 3'b100 && mon_beats == 1, "R11 held beat completes", mon_beats, 1);
    clear_all();

    // constrained random walks
    for (int it = 0; it < 6; it++) begin
      n = 1 + $urandom_range(0, 2);
      exp_b = 0;
      for (int k = 0; k < n; k++) begin
        logic [15:0] len;
        len = 16'(1 + $urandom_range(0, 39));
        put_desc(k, $urandom & 32'hFFFF_FFFC, len, k == n - 1);
        exp_b += tb_beats(len);
      end
      dir = 1'($urandom_range(0, 1));
      start_job(dir);
      wait_idle(d);
      chk(d[2:0] == 3'b100, "R8 random completion", d, 32'h4);
      chk(mon_beats == exp_b && mon_bad == 0, "R6 random beat walk", mon_beats, exp_b);
      chk(xfer_to_mem == dir, "R7 random direction", xfer_to_mem, dir);
      clear_all();
    end

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule